// File: doc/BRIEF.md
# Addressable-Tap Delay Line

This block is a one-bit delay line with a run-time selectable length. Every clock edge on which the enable is high moves one new bit into the first stage, and each stored bit moves one stage deeper. A tap address picks which stage appears on the main output. The delay can therefore be retuned while the line runs, for example to even out two pipeline branches whose latencies differ.

A second output always shows the deepest stage. That output can feed the serial input of another copy of the block, so lines can be chained for delays beyond the stage count. An optional output flop behind the tap adds one more cycle of depth. For wider data, place one copy per bit.

The stored stages have no reset. The reset input clears only the optional output flop.

Top module: `tap_delay_line`

## Requirements
- R1: On a rising clock edge with `ce` high, stage 0 takes `din` and every stage k (k > 0) takes the old value of stage k-1. Exactly one bit enters per enabled edge.
- R2: On a rising edge with `ce` low, all stages keep their values. `tap_out` and `casc_out` do not change while `tap_sel` is held.
- R3: With `tap_sel` = N, `tap_out` shows stage N. This is the bit presented on `din` N+1 enabled edges earlier. N = 0 gives one cycle of delay, and N = 15 gives sixteen.
- R4: `tap_out` is a combinational read of the addressed stage. A new `tap_sel` value appears on `tap_out` in the same cycle, with no clock edge needed.
- R5: `casc_out` always shows stage 15 (the last stage), whatever the value of `tap_sel`. This is the bit from 16 enabled edges earlier.
- R6: With the output flop fitted (default), `reg_out` loads the current `tap_out` on an edge with `ce` high and holds on an edge with `ce` low. This gives a delay of N+2 enabled edges.
- R7: A synchronous active-high `rst` clears `reg_out` to 0 at the next edge and takes priority over `ce`. It does not clear or stop the shift stages, which still follow R1 and R2 during reset.
- R8: When `casc_out` of one copy drives `din` of a second copy with the same `ce`, the second copy's `tap_out` with address M shows the first copy's input from 16+M+1 enabled edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of the output flop only |
| ce | input | 1 | Shift enable; also the load enable of the output flop |
| din | input | 1 | Serial data input |
| tap_sel | input | 4 | Address of the stage driving `tap_out` (delay = value + 1) |
| tap_out | output | 1 | Addressed stage, combinational |
| casc_out | output | 1 | Last stage, for chaining |
| reg_out | output | 1 | `tap_out` registered on enabled edges |

## Verification
The line is driven with several input patterns:
- A long pseudo-random stream with the enable held high exposes any stage that is skipped or doubled.
- A sweep over every tap address confirms the N+1 delay at each depth.
- A lone 1 in a field of zeros pins the exact delay of the tap, the cascade and a chained second copy with no room for aliasing.
- Bursts with the enable low while the address moves separate true holding from shifting, and separate the combinational tap read from a registered one.
- A stream with the enable toggled at random, plus a reset in mid-run, shows that the output flop keeps step with the enable and that reset leaves the stored bits alone.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    // Stage count the block is normally built with.
    localparam int TDL_DEFAULT_STAGES = 16;

    // Bundle of the three observable views of the line.
    typedef struct packed {
        logic tap;      // addressed stage
        logic cascade;  // deepest stage
        logic held;     // registered tap
    } tdl_view_t;

    // Delay in enabled edges from din to the combinational tap.
    function automatic int tdl_tap_delay(input int addr);
        return addr + 1;
    endfunction

endpackage

// File: rtl/tdl_shift_chain.sv
module tdl_shift_chain #(
    parameter int STAGES = tdl_pkg::TDL_DEFAULT_STAGES
) (
    input  logic              clk,
    input  logic              ce,
    input  logic              din,
    output logic [STAGES-1:0] stages
);
    // One flop per stage, no reset: contents are defined by what is shifted in.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic nxt;
        if (k == 0) begin : g_head
            assign nxt = din;
        end else begin : g_body
            assign nxt = stages[k-1];
        end
        always_ff @(posedge clk) begin
            if (ce) begin
                stages[k] <= nxt;
            end
        end
    end
endmodule

// File: rtl/tdl_tap_mux.sv
module tdl_tap_mux #(
    parameter int STAGES = tdl_pkg::TDL_DEFAULT_STAGES,
    parameter int AW     = $clog2(STAGES)
) (
    input  logic [STAGES-1:0] stages,
    input  logic [AW-1:0]     sel,
    output logic              tap
);
    always_comb begin
        tap = 1'b0;
        for (int k = 0; k < STAGES; k++) begin
            if (sel == AW'(k)) begin
                tap = stages[k];
            end
        end
    end
endmodule

// File: rtl/tdl_out_stage.sv
module tdl_out_stage #(
    parameter bit USE_OUT_REG = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic d,
    output logic q
);
    if (USE_OUT_REG) begin : g_flop
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 1'b0;
            end else if (ce) begin
                q <= d;
            end
        end
    end else begin : g_wire
        logic unused_ok;
        assign unused_ok = clk ^ rst ^ ce;
        assign q = d;
    end
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
    parameter int  STAGES      = tdl_pkg::TDL_DEFAULT_STAGES,
    parameter bit  USE_OUT_REG = 1'b1,
    localparam int AW          = $clog2(STAGES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          din,
    input  logic [AW-1:0] tap_sel,
    output logic          tap_out,
    output logic          casc_out,
    output logic          reg_out
);
    import tdl_pkg::*;

    logic [STAGES-1:0] stages;
    tdl_view_t         view;
    logic              tap_w;
    logic              held_w;

    tdl_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk    (clk),
        .ce     (ce),
        .din    (din),
        .stages (stages)
    );

    tdl_tap_mux #(.STAGES(STAGES), .AW(AW)) u_mux (
        .stages (stages),
        .sel    (tap_sel),
        .tap    (tap_w)
    );

    tdl_out_stage #(.USE_OUT_REG(USE_OUT_REG)) u_out (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .d   (tap_w),
        .q   (held_w)
    );

    assign view.tap     = tap_w;
    assign view.cascade = stages[STAGES-1];
    assign view.held    = held_w;

    assign tap_out  = view.tap;
    assign casc_out = view.cascade;
    assign reg_out  = view.held;
endmodule

// File: rtl/tdl_checker.sv
module tdl_checker #(
    parameter int STAGES      = 16,
    parameter bit USE_OUT_REG = 1'b1,
    parameter int AW          = $clog2(STAGES)
) (
    input logic          clk,
    input logic          rst,
    input logic          ce,
    input logic          din,
    input logic [AW-1:0] tap_sel,
    input logic          tap_out,
    input logic          casc_out,
    input logic          reg_out
);
    localparam int CW = $clog2(STAGES + 1);

    // Counts enabled edges since reset; once it reaches STAGES every stage
    // holds a bit that was really shifted in.
    logic [CW-1:0] fill_cnt;
    logic          full;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt <= '0;
        end else if (ce && (fill_cnt != CW'(STAGES))) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end
    assign full = (fill_cnt == CW'(STAGES));

    // R2: a disabled edge with a steady address leaves the tap unchanged
    a_r2_tap_hold: assert property (@(posedge clk) disable iff (rst)
        (full && !ce) |=> (!$stable(tap_sel) || $stable(tap_out)));

    // R2, R5: the cascade output holds across a disabled edge
    a_r5_casc_hold: assert property (@(posedge clk) disable iff (rst)
        (full && !ce) |=> $stable(casc_out));

    // R1, R3: with address 0 the tap shows the bit taken in at the last enabled edge
    a_r3_first_stage: assert property (@(posedge clk) disable iff (rst)
        (full && ce) |=> (tap_sel != '0 || tap_out == $past(din)));

    if (USE_OUT_REG) begin : g_reg_chk
        // R6: an enabled edge loads the tap into the output flop
        a_r6_load: assert property (@(posedge clk) disable iff (rst)
            (full && ce) |=> (reg_out == $past(tap_out)));
        // R6: a disabled edge keeps the output flop
        a_r6_hold: assert property (@(posedge clk) disable iff (rst)
            (full && !ce) |=> $stable(reg_out));
    end else begin : g_wire_chk
        // R6: without the flop, the registered output follows the tap
        a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
            full |-> (reg_out == tap_out));
    end
endmodule

bind tap_delay_line tdl_checker #(
    .STAGES      (STAGES),
    .USE_OUT_REG (USE_OUT_REG),
    .AW          (AW)
) u_tdl_checker (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .din      (din),
    .tap_sel  (tap_sel),
    .tap_out  (tap_out),
    .casc_out (casc_out),
    .reg_out  (reg_out)
);

// File: tb/tap_delay_line_bench.sv
`timescale 1ns/1ps
module tap_delay_line_bench;

    localparam int HW = 40;  // bench history depth, newest bit at index 0

    typedef struct {
        string tag;
        logic  tap;   bit tap_v;
        logic  casc;  bit casc_v;
        logic  rg;    bit rg_v;
        logic  tapb;  bit tapb_v;
        logic  cascb; bit cascb_v;
        logic  rgb;   bit rgb_v;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       ce  = 1'b0;
    logic       din = 1'b0;
    logic [3:0] sel_a = '0;
    logic [3:0] sel_b = '0;
    logic       tap_a, casc_a, reg_a;
    logic       tap_b, casc_b, reg_b;

    int n_tests = 0;
    int n_fail  = 0;

    exp_t          sb[$];
    logic [HW-1:0] hist = '0;
    int            fill = 0;
    logic          ra = 1'b0, rb = 1'b0;
    bit            ra_v = 0, rb_v = 0;
    logic [15:0]   lfsr = 16'hACE1;
    bit            done = 0;

    always #5 clk = ~clk;

    tap_delay_line u_tap_delay_line (
        .clk(clk), .rst(rst), .ce(ce), .din(din), .tap_sel(sel_a),
        .tap_out(tap_a), .casc_out(casc_a), .reg_out(reg_a)
    );

    // R8: second copy chained from the cascade output of the first
    tap_delay_line u_tap_delay_line_b (
        .clk(clk), .rst(rst), .ce(ce), .din(casc_a), .tap_sel(sel_b),
        .tap_out(tap_b), .casc_out(casc_b), .reg_out(reg_b)
    );

    task automatic chk(string tag, string what, logic act, logic expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, expv, $time);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Driver: apply one cycle of inputs and push the expected outputs
    // seen after the following rising edge.
    task automatic step(string tag, logic r, logic e, logic d, logic [3:0] sa, logic [3:0] sbb);
        exp_t          x;
        logic [HW-1:0] nh;
        int            nf;
        @(negedge clk);
        rst = r; ce = e; din = d; sel_a = sa; sel_b = sbb;
        nh = e ? {hist[HW-2:0], d} : hist;
        nf = e ? ((fill < HW) ? fill + 1 : HW) : fill;
        // R6, R7: output flops use the tap before this edge
        if (r) begin
            ra = 1'b0; ra_v = 1; rb = 1'b0; rb_v = 1;
        end else if (e) begin
            ra = hist[sa];       ra_v = ra_v && (int'(sa) < fill);
            rb = hist[16 + sbb]; rb_v = rb_v && (16 + int'(sbb) < fill);
        end
        x.tag    = tag;
        x.tap    = nh[sa];        x.tap_v   = int'(sa) < nf;
        x.casc   = nh[15];        x.casc_v  = nf >= 16;
        x.rg     = ra;            x.rg_v    = ra_v;
        x.tapb   = nh[16 + sbb];  x.tapb_v  = 16 + int'(sbb) < nf;
        x.cascb  = nh[31];        x.cascb_v = nf >= 32;
        x.rgb    = rb;            x.rgb_v   = rb_v;
        sb.push_back(x);
        hist = nh;
        fill = nf;
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                if (x.tap_v)   chk(x.tag, "R3 tap_out",         tap_a,  x.tap);
                if (x.casc_v)  chk(x.tag, "R5 casc_out",        casc_a, x.casc);
                if (x.rg_v)    chk(x.tag, "R6 reg_out",         reg_a,  x.rg);
                if (x.tapb_v)  chk(x.tag, "R8 chained tap_out", tap_b,  x.tapb);
                if (x.cascb_v) chk(x.tag, "R8 chained casc",    casc_b, x.cascb);
                if (x.rgb_v)   chk(x.tag, "R6 chained reg_out", reg_b,  x.rgb);
            end
        end
    end

    // R4: move the address mid-cycle with no edge and read the tap at once
    task automatic comb_probe(logic [3:0] sa);
        @(negedge clk);
        ce = 1'b0;
        #1;
        sel_a = sa;
        #1;
        chk("R4 combinational", "tap_out", tap_a, hist[sa]);
    endtask

    initial begin
        // R7: reset clears the output flops
        step("R7 reset", 1'b1, 1'b1, 1'b0, 4'd0, 4'd0);
        step("R7 reset", 1'b1, 1'b1, 1'b0, 4'd0, 4'd0);
        // R1: fill with a pseudo-random stream, shallowest tap
        for (int i = 0; i < 36; i++) step("R1 shift", 1'b0, 1'b1, next_bit(), 4'd0, 4'd15);
        // R3: sweep every address
        for (int s = 0; s < 16; s++)
            for (int j = 0; j < 3; j++)
                step("R3 sweep", 1'b0, 1'b1, next_bit(), 4'(s), 4'(15 - s));
        // R3, R5, R8: a lone 1 among zeros
        for (int i = 0; i < 34; i++) step("R3 impulse", 1'b0, 1'b1, 1'b0, 4'd7, 4'd3);
        step("R3 impulse", 1'b0, 1'b1, 1'b1, 4'd7, 4'd3);
        for (int i = 0; i < 40; i++) step("R8 impulse", 1'b0, 1'b1, 1'b0, 4'd7, 4'd3);
        // R2: refill, then hold with a toggling din and a moving address
        for (int i = 0; i < 34; i++) step("R1 refill", 1'b0, 1'b1, next_bit(), 4'd2, 4'd9);
        for (int i = 0; i < 8; i++) step("R2 hold", 1'b0, 1'b0, i[0], 4'(i * 2), 4'(i));
        for (int s = 0; s < 16; s++) comb_probe(4'(s));
        step("R2 hold", 1'b0, 1'b0, 1'b1, 4'd5, 4'd5);
        // R6: enable toggled at random with a random address
        for (int i = 0; i < 80; i++) begin
            logic e, d;
            logic [3:0] s;
            e = next_bit();
            d = next_bit();
            s = lfsr[7:4];
            step("R6 gated", 1'b0, e, d, s, ~s);
        end
        // R7: reset in mid-run clears only the flops, the stages keep shifting
        step("R7 reset midrun", 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);
        for (int i = 0; i < 20; i++) step("R7 after reset", 1'b0, 1'b1, next_bit(), 4'd11, 4'd4);
        step("R7 drain", 1'b0, 1'b0, 1'b0, 4'd11, 4'd4);
        step("R7 drain", 1'b0, 1'b0, 1'b0, 4'd11, 4'd4);
        @(posedge clk);
        #4;
        done = 1;
    end

    // Watchdog
    initial begin
        fork
            wait (done);
            begin
                #1_000_000;
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired at %0t", $time);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule